// File: doc/BRIEF.md
# Shared-Memory Request/Grant Access Controller

This block sits between a bus-interface core and a 2K x 16 memory that it shares with a host processor. An outside arbiter decides who owns the memory. When the core needs one word read or written, it pulses a request with the address, the direction and any write data. The controller stores that command. It raises its memory request and waits for the arbiter's grant. Once granted, it performs a single access cycle with chip select active. It then drops the request and reports completion with a one-cycle done pulse. For a read, the pulse comes with the captured word.

Only the address outputs can go to high impedance, and this happens whenever the external address enable is low, whatever the controller's state. Chip select and the read/write line are always driven. The data bus is an input except during the access cycle of a write. If the arbiter takes the grant away during the access cycle, the access is dropped and the request stays raised. No done pulse is given, and the access is repeated after the next grant.

The state machine has four states:
- ST_IDLE: nothing pending.
- ST_REQ: request raised, waiting for the grant.
- ST_ACCESS: chip select active for one cycle.
- ST_DONE: request released, done pulsed.

The transitions are:
- T_START: ST_IDLE to ST_REQ on a core pulse.
- T_GRANT: ST_REQ to ST_ACCESS when the grant is high.
- T_LOST: ST_ACCESS back to ST_REQ when the grant is low at the end of the access cycle.
- T_FINISH: ST_ACCESS to ST_DONE when the grant is still high.
- T_RETURN: ST_DONE to ST_IDLE, unconditionally.

Top module: `dma_mem_port`

## Requirements
- R1: During and after reset, `mem_req`, `mem_cs` and `done` are low, and the controller does not drive `mem_data`.
- R2: A `core_req` pulse seen in idle raises `mem_req` on the next cycle, and `mem_req` stays high until the done cycle.
- R3: A high `mem_gnt` while no request is outstanding starts no access: `mem_cs`, `mem_req` and `done` stay low.
- R4: After the grant is seen high while requesting, exactly one cycle with `mem_cs` = 1 follows. In that cycle `mem_wr` is 1 for a write and 0 for a read, and `mem_addr` holds the stored core address. `done` rises 3 + d cycles after the `core_req` cycle, where d is the number of cycles the grant was withheld.
- R5: When `addr_oe` is 0, the controller releases `mem_addr` in every state, so another master can drive it.
- R6: `mem_cs` and `mem_wr` are always driven to a known level after reset and are never released.
- R7: The controller drives `mem_data` only in the access cycle of a write, and there it drives the stored write data. At all other times the bus is an input.
- R8: For a read, the word on `mem_data` at the end of the access cycle appears on `rdata` together with `done`. `done` lasts exactly one cycle, during which `mem_req` is low.
- R9: If `mem_gnt` is low at the end of the access cycle, the controller returns to requesting with `mem_req` still high and gives no `done`. It repeats the access after the next grant.
- R10: A `core_req` pulse while a command is pending is ignored. The pending command's address, direction and data are used unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | One-cycle command pulse from the core, accepted only in idle |
| core_addr | input | 11 | Word address of the command |
| core_wr | input | 1 | Command direction: 1 write, 0 read |
| core_wdata | input | 16 | Word to write |
| mem_gnt | input | 1 | Grant from the external arbiter |
| addr_oe | input | 1 | Address output enable; 0 releases `mem_addr` |
| mem_req | output | 1 | Memory access request to the arbiter |
| mem_addr | output | 11 | Three-state memory address |
| mem_cs | output | 1 | Memory chip select, active high, always driven |
| mem_wr | output | 1 | Memory direction: 1 write, 0 read, always driven |
| mem_data | inout | 16 | Shared memory data bus |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word captured by the last completed read |

## Verification
A wrong state register shows up at the ports within one cycle. A controller stuck in idle never raises `mem_req`. One stuck in the request state never asserts `mem_cs`, which the latency check catches. A repeated access cycle shows up as a second `mem_cs` cycle or a shifted `done`. A missed grant-loss branch produces a `done` in the cycle right after the grant drops. Wrong bus-enable state appears as contention on `mem_data` or `mem_addr` against values the bench drives. The read word, or the pattern a bench master drives in idle or while the address enable is low, then comes back altered.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    localparam int DMP_ADDR_W = 11;
    localparam int DMP_DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } dmp_state_e;

endpackage

// File: rtl/dmp_ctrl_fsm.sv
module dmp_ctrl_fsm
    import dmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic mem_gnt,
    input  logic lat_wr,
    output logic accept,
    output logic capture,
    output logic mem_req,
    output logic mem_cs,
    output logic mem_wr,
    output logic dbus_oe,
    output logic done
);

    dmp_state_e state_q;
    dmp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_START, T_GRANT, T_LOST, T_FINISH, T_RETURN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (core_req) state_d = ST_REQ;
            ST_REQ:    if (mem_gnt)  state_d = ST_ACCESS;
            ST_ACCESS: state_d = mem_gnt ? ST_DONE : ST_REQ;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the present state
    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        mem_req = 1'b0;
        mem_cs  = 1'b0;
        mem_wr  = 1'b0;
        dbus_oe = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = core_req;
            end
            ST_REQ: begin
                mem_req = 1'b1;
            end
            ST_ACCESS: begin
                mem_req = 1'b1;
                mem_cs  = 1'b1;
                mem_wr  = lat_wr;
                dbus_oe = lat_wr;
                capture = mem_gnt & ~lat_wr;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dmp_xfer_regs.sv
module dmp_xfer_regs #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] core_addr,
    input  logic          core_wr,
    input  logic [DW-1:0] core_wdata,
    input  logic [DW-1:0] dbus_in,
    output logic [AW-1:0] lat_addr,
    output logic          lat_wr,
    output logic [DW-1:0] lat_wdata,
    output logic [DW-1:0] rdata
);

    // Command held from acceptance until the next acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= core_addr;
            lat_wr    <= core_wr;
            lat_wdata <= core_wdata;
        end
    end

    // Read word taken at the closing edge of a granted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dbus_in;
        end
    end

endmodule

// File: rtl/dmp_bus_pads.sv
module dmp_bus_pads #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          abus_oe,
    input  logic [AW-1:0] abus_val,
    output wire  [AW-1:0] mem_addr,
    input  logic          dbus_oe,
    input  logic [DW-1:0] dbus_val,
    inout  wire  [DW-1:0] mem_data,
    output logic [DW-1:0] dbus_in
);

    genvar gi;
    generate
        for (gi = 0; gi < AW; gi++) begin : g_apad
            assign mem_addr[gi] = abus_oe ? abus_val[gi] : 1'bz;
        end
        for (gi = 0; gi < DW; gi++) begin : g_dpad
            assign mem_data[gi] = dbus_oe ? dbus_val[gi] : 1'bz;
        end
    endgenerate

    assign dbus_in = mem_data;

endmodule

// File: rtl/dma_mem_port.sv
module dma_mem_port #(
    parameter int AW = dmp_pkg::DMP_ADDR_W,
    parameter int DW = dmp_pkg::DMP_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_wr,
    input  logic [DW-1:0] core_wdata,
    input  logic          mem_gnt,
    input  logic          addr_oe,
    output logic          mem_req,
    output wire  [AW-1:0] mem_addr,
    output logic          mem_cs,
    output logic          mem_wr,
    inout  wire  [DW-1:0] mem_data,
    output logic          done,
    output logic [DW-1:0] rdata
);

    logic          accept;
    logic          capture;
    logic          dbus_oe;
    logic          lat_wr;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [DW-1:0] dbus_in;

    dmp_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_req (core_req),
        .mem_gnt  (mem_gnt),
        .lat_wr   (lat_wr),
        .accept   (accept),
        .capture  (capture),
        .mem_req  (mem_req),
        .mem_cs   (mem_cs),
        .mem_wr   (mem_wr),
        .dbus_oe  (dbus_oe),
        .done     (done)
    );

    dmp_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .core_addr  (core_addr),
        .core_wr    (core_wr),
        .core_wdata (core_wdata),
        .dbus_in    (dbus_in),
        .lat_addr   (lat_addr),
        .lat_wr     (lat_wr),
        .lat_wdata  (lat_wdata),
        .rdata      (rdata)
    );

    dmp_bus_pads #(.AW(AW), .DW(DW)) u_pads (
        .abus_oe  (addr_oe),
        .abus_val (lat_addr),
        .mem_addr (mem_addr),
        .dbus_oe  (dbus_oe),
        .dbus_val (lat_wdata),
        .mem_data (mem_data),
        .dbus_in  (dbus_in)
    );

endmodule

// File: rtl/dma_mem_port_chk.sv
module dma_mem_port_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_gnt,
    input logic mem_req,
    input logic mem_cs,
    input logic mem_wr,
    input logic dbus_oe,
    input logic done
);

    // R2: a raised request is held while waiting for the grant
    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_cs) |=> mem_req);

    // R3: no chip select unless a request was already outstanding
    p_no_cs_without_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> !mem_cs);

    // R4: the access lasts one cycle and sits inside the request
    p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |=> !mem_cs);
    p_cs_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> mem_req);

    // R6: control lines are always at a known level
    p_ctl_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({mem_cs, mem_wr, mem_req, done}));

    // R7: the data bus is driven only in a write access cycle
    p_dbus_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (mem_cs && mem_wr));

    // R8: done is a single pulse with the request released
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R9: losing the grant in the access cycle keeps requesting, no done
    p_lost_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && !mem_gnt) |=> (mem_req && !done && !mem_cs));

endmodule

bind dma_mem_port dma_mem_port_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_gnt (mem_gnt),
    .mem_req (mem_req),
    .mem_cs  (mem_cs),
    .mem_wr  (mem_wr),
    .dbus_oe (dbus_oe),
    .done    (done)
);

// File: tb/dma_mem_port_tb_top.sv
module dma_mem_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    // {wr[31], addr[30:20], wdata[19:4], grant delay[3:0]}
    localparam logic [31:0] VEC [0:10] = '{
        {1'b1, 11'd5,    16'hBEEF, 4'd0},
        {1'b0, 11'd5,    16'h0000, 4'd0},
        {1'b0, 11'd0,    16'h0000, 4'd1},
        {1'b0, 11'd2047, 16'h0000, 4'd0},
        {1'b1, 11'd2047, 16'h1234, 4'd3},
        {1'b0, 11'd2047, 16'h0000, 4'd0},
        {1'b1, 11'd0,    16'hFFFF, 4'd0},
        {1'b0, 11'd0,    16'h0000, 4'd7},
        {1'b0, 11'd1000, 16'h0000, 4'd2},
        {1'b1, 11'd1000, 16'h0001, 4'd5},
        {1'b0, 11'd1000, 16'h0000, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          core_req;
    logic [AW-1:0] core_addr;
    logic          core_wr;
    logic [DW-1:0] core_wdata;
    logic          mem_gnt;
    logic          addr_oe;
    logic          mem_req;
    wire  [AW-1:0] mem_addr;
    logic          mem_cs;
    logic          mem_wr;
    wire  [DW-1:0] mem_data;
    logic          done;
    logic [DW-1:0] rdata;

    logic          host_a_drv;
    logic [AW-1:0] host_a_val;
    logic          host_d_drv;
    logic [DW-1:0] host_d_val;

    logic [DW-1:0] mem_arr [0:DEPTH-1];
    logic [DW-1:0] exp_arr [0:DEPTH-1];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_mem_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req),
        .core_addr  (core_addr),
        .core_wr    (core_wr),
        .core_wdata (core_wdata),
        .mem_gnt    (mem_gnt),
        .addr_oe    (addr_oe),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_cs     (mem_cs),
        .mem_wr     (mem_wr),
        .mem_data   (mem_data),
        .done       (done),
        .rdata      (rdata)
    );

    // Bench memory and a second bus master
    assign mem_addr = host_a_drv ? host_a_val : {AW{1'bz}};
    assign mem_data = (mem_cs && !mem_wr) ? mem_arr[mem_addr] :
                      host_d_drv ? host_d_val : {DW{1'bz}};

    always @(posedge clk) begin
        if (mem_cs && mem_wr && mem_gnt) mem_arr[mem_addr] <= mem_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic do_op(input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input int dly);
        int n;
        int cs_cnt;
        @(negedge clk);
        core_req = 1'b1; core_wr = wr; core_addr = a; core_wdata = wd;
        @(negedge clk);
        core_req = 1'b0; core_wr = ~wr; core_addr = ~a; core_wdata = ~wd;
        chk(mem_req === 1'b1, "R2", "request after start", {31'd0, mem_req}, 32'd1);
        n = 1;
        cs_cnt = 0;
        while (done !== 1'b1 && n < 64) begin
            if (mem_cs === 1'b1) begin
                cs_cnt++;
                chk(mem_wr === wr, "R4", "direction in access", {31'd0, mem_wr}, {31'd0, wr});
                chk(mem_addr === a, "R4", "address in access", {21'd0, mem_addr}, {21'd0, a});
                if (wr) chk(mem_data === wd, "R7", "write data on bus", {16'd0, mem_data}, {16'd0, wd});
            end
            if (n < 3 + dly) chk(mem_req === 1'b1, "R2", "request held", {31'd0, mem_req}, 32'd1);
            if (n >= 1 + dly) mem_gnt = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(n == 3 + dly, "R4", "done latency", n, 3 + dly);
        chk(cs_cnt == 1, "R4", "access cycle count", cs_cnt, 32'd1);
        chk(mem_req === 1'b0, "R8", "request low with done", {31'd0, mem_req}, 32'd0);
        if (!wr) chk(rdata === exp_arr[a], "R8", "read word", {16'd0, rdata}, {16'd0, exp_arr[a]});
        else exp_arr[a] = wd;
        mem_gnt = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R8", "done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_arr[i] = DW'((i * 37) ^ 16'hA5C3);
            exp_arr[i] = DW'((i * 37) ^ 16'hA5C3);
        end
        rst_n = 1'b0; core_req = 1'b0; core_addr = '0; core_wr = 1'b0; core_wdata = '0;
        mem_gnt = 1'b0; addr_oe = 1'b1;
        host_a_drv = 1'b0; host_a_val = '0; host_d_drv = 1'b0; host_d_val = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_req === 1'b0 && mem_cs === 1'b0 && done === 1'b0, "R1", "outputs in reset",
            {29'd0, mem_req, mem_cs, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req === 1'b0 && mem_cs === 1'b0 && done === 1'b0, "R1", "outputs after reset",
            {29'd0, mem_req, mem_cs, done}, 32'd0);
        host_d_drv = 1'b1; host_d_val = 16'h5A5A;
        @(negedge clk);
        chk(mem_data === 16'h5A5A, "R1", "data bus released after reset", {16'd0, mem_data}, 32'h5A5A);
        host_d_drv = 1'b0;

        // Vector table
        for (int i = 0; i < 11; i++) begin
            do_op(VEC[i][31], VEC[i][30:20], VEC[i][19:4], int'(VEC[i][3:0]));
        end

        // R7: after a write of A5A5 the bus is released in idle
        do_op(1'b1, 11'd77, 16'hA5A5, 0);
        host_d_drv = 1'b1; host_d_val = 16'h5A5A;
        @(negedge clk);
        chk(mem_data === 16'h5A5A, "R7", "bus input in idle after write", {16'd0, mem_data}, 32'h5A5A);
        chk(mem_cs === 1'b0 && mem_wr === 1'b0, "R6", "controls driven low in idle",
            {30'd0, mem_cs, mem_wr}, 32'd0);
        host_d_drv = 1'b0;

        // R3: grant without request
        mem_gnt = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(mem_cs === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R3", "grant ignored in idle",
                {29'd0, mem_cs, mem_req, done}, 32'd0);
        end
        mem_gnt = 1'b0;

        // R9: grant lost in the access cycle
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b0; core_addr = 11'd9;
        @(negedge clk);
        core_req = 1'b0; mem_gnt = 1'b1;
        @(negedge clk);
        chk(mem_cs === 1'b1, "R9", "access reached", {31'd0, mem_cs}, 32'd1);
        mem_gnt = 1'b0;
        @(negedge clk);
        chk(mem_cs === 1'b0 && mem_req === 1'b1 && done === 1'b0, "R9", "back to requesting, no done",
            {29'd0, mem_cs, mem_req, done}, 32'd2);
        mem_gnt = 1'b1;
        @(negedge clk);
        chk(mem_cs === 1'b1, "R9", "access repeated", {31'd0, mem_cs}, 32'd1);
        @(negedge clk);
        chk(done === 1'b1 && rdata === exp_arr[9], "R9", "done after retry with word",
            {15'd0, done, rdata}, {15'd0, 1'b1, exp_arr[9]});
        mem_gnt = 1'b0;
        @(negedge clk);

        // R10: a second command while one is pending is ignored
        core_req = 1'b1; core_wr = 1'b0; core_addr = 11'd20;
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b1; core_addr = 11'd30; core_wdata = 16'h0F0F;
        @(negedge clk);
        core_req = 1'b0; mem_gnt = 1'b1;
        @(negedge clk);
        chk(mem_cs === 1'b1 && mem_wr === 1'b0 && mem_addr === 11'd20, "R10", "pending command kept",
            {19'd0, mem_cs, mem_wr, mem_addr}, {19'd0, 1'b1, 1'b0, 11'd20});
        @(negedge clk);
        chk(done === 1'b1 && rdata === exp_arr[20], "R10", "pending read completed",
            {15'd0, done, rdata}, {15'd0, 1'b1, exp_arr[20]});
        mem_gnt = 1'b0;
        do_op(1'b0, 11'd30, 16'h0000, 0);

        // R5: address released when the enable is low
        addr_oe = 1'b0; host_a_drv = 1'b1; host_a_val = 11'b010_0100_1011;
        @(negedge clk);
        chk(mem_addr === 11'b010_0100_1011, "R5", "address released in idle",
            {21'd0, mem_addr}, {21'd0, 11'b010_0100_1011});
        core_req = 1'b1; core_wr = 1'b0; core_addr = 11'b101_1011_0100;
        @(negedge clk);
        core_req = 1'b0; mem_gnt = 1'b1;
        @(negedge clk);
        chk(mem_cs === 1'b1 && mem_addr === 11'b010_0100_1011, "R5", "address released in access",
            {20'd0, mem_cs, mem_addr}, {20'd0, 1'b1, 11'b010_0100_1011});
        @(negedge clk);
        chk(done === 1'b1, "R5", "access completes with address released", {31'd0, done}, 32'd1);
        mem_gnt = 1'b0; host_a_drv = 1'b0; addr_oe = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule